// File: doc/BRIEF.md
# Two-Tone FSK Proximity Tag Waveform Generator

This block produces the modulation bit stream that a low-frequency proximity tag sends back to a reader. It emits one bit per sample strobe, which a downstream stage uses to load or release the antenna coil. Every half-bit is made from a repeated carrier-divided sub-pattern of one of two kinds. The short kind repeats every 8 samples and the long kind repeats every 10 samples. The pairing of the two kinds inside a bit carries the data value.

A frame holds a start marker that no valid data bit can produce, then the 44-bit identifier, most significant bit first. One short filler period goes ahead of every group of four data bits. After the last data bit the next frame starts at once. The generator repeats frames until the enable input drops. The identifier is sampled on a start request and again at every frame boundary, so a new value written mid-frame appears cleanly in the next frame.

Top module: `fsk_tagwave`

## Requirements
- R1: A short half-bit is 48 samples: six repeats of the 8-sample period 1,1,0,0,0,0,0,0.
- R2: A long half-bit is 50 samples: five repeats of the 10-sample period 1,1,1,0,0,0,0,0,0,0.
- R3: Data bits go out from bit 43 down to bit 0. A 1 is a long half followed by a short half. A 0 is a short half followed by a long half.
- R4: Each frame opens with 8 halves in this order: short, short, short, long, long, long, short, long (392 samples).
- R5: One filler period (1,1,0,0,0,0,0,0) goes ahead of each of data bits 43, 39, 35, ..., 3. A frame is 4792 samples.
- R6: The sample after the last sample of bit 0 is the first sample of the next start marker. There is no gap.
- R7: The stream moves on by exactly one sample for each cycle in which `smp_i` is high. With `smp_i` low, the position holds.
- R8: `sof_o` is high only in a strobe cycle that emits the first sample of a start marker.
- R9: `id_i` is captured on a start request and at each frame wrap. A change of `id_i` inside a frame does not alter that frame.
- R10: While `en_i` is low, `mod_o` and `sof_o` are 0 and a start request is ignored. After `en_i` returns high, output stays 0 until a start request.
- R11: A start request (`load_i` high with `en_i` high) during a frame restarts output at marker sample 0 with the newly captured identifier.
- R12: After reset the generator is idle, and `mod_o` and `sof_o` are 0 even with enable and strobe high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Generator enable; low stops and clears the generator |
| load_i | input | 1 | Start request: capture `id_i` and begin at the start marker |
| smp_i | input | 1 | Sample strobe; one output sample per high cycle |
| id_i | input | 44 | Tag identifier |
| mod_o | output | 1 | Modulation bit for the current sample |
| sof_o | output | 1 | High on the strobe of the first marker sample |

## Verification
The bench targets the seams between segments. It probes the last sample of each period, the first filler sample ahead of bit 43, the half-bit boundary where a bit value picks a 48- or 50-sample half, and the first sample after bit 0. A generator whose period counter is off by one, or that swaps the half order of a bit, shows it at these fixed sample indices. A design that drops the filler, or adds a gap at the wrap, shifts every later sample. An identifier change in mid-frame, a start request in mid-frame and enable dropped in mid-frame each go after the capture and restart paths: a design that takes the new identifier early, or resumes on re-enable without a start request, emits bits the model rejects. Strobe gaps check that the position holds while no strobe is given.

// File: rtl/fsktag_pkg.sv
package fsktag_pkg;

    typedef enum logic [1:0] {
        SLOT_MARK,
        SLOT_FILL,
        SLOT_HALF0,
        SLOT_HALF1
    } slot_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fsktag_cell.sv
module fsktag_cell
    import fsktag_pkg::*;
#(
    parameter int DIV_A  = 8,
    parameter int HIGH_A = 2,
    parameter int REP_A  = 6,
    parameter int DIV_B  = 10,
    parameter int HIGH_B = 3,
    parameter int REP_B  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic adv_i,
    input  logic wide_i,
    input  logic short_i,
    output logic bit_o,
    output logic first_o,
    output logic last_o
);

    localparam int DIV_MAX = max2(DIV_A, DIV_B);
    localparam int REP_MAX = max2(REP_A, REP_B);
    localparam int PH_W    = $clog2(DIV_MAX);
    localparam int RP_W    = $clog2(REP_MAX + 1);

    localparam logic [PH_W-1:0] PH_END_A = PH_W'(DIV_A - 1);
    localparam logic [PH_W-1:0] PH_END_B = PH_W'(DIV_B - 1);
    localparam logic [PH_W-1:0] HI_A     = PH_W'(HIGH_A);
    localparam logic [PH_W-1:0] HI_B     = PH_W'(HIGH_B);
    localparam logic [RP_W-1:0] RP_END_A = RP_W'(REP_A - 1);
    localparam logic [RP_W-1:0] RP_END_B = RP_W'(REP_B - 1);

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic [RP_W-1:0] rep;
    } cell_t;

    cell_t           st_q, st_d;
    logic [PH_W-1:0] ph_end;
    logic [PH_W-1:0] hi_lim;
    logic [RP_W-1:0] rp_end;
    logic            per_end;

    always_comb begin
        ph_end  = wide_i ? PH_END_B : PH_END_A;
        hi_lim  = wide_i ? HI_B : HI_A;
        rp_end  = short_i ? '0 : (wide_i ? RP_END_B : RP_END_A);
        per_end = (st_q.phase == ph_end);
        last_o  = per_end && (st_q.rep == rp_end);
        first_o = (st_q.phase == '0) && (st_q.rep == '0);
        bit_o   = (st_q.phase < hi_lim);

        st_d = st_q;
        if (clr_i) begin
            st_d = '0;
        end else if (adv_i) begin
            if (per_end) begin
                st_d.phase = '0;
                st_d.rep   = last_o ? '0 : st_q.rep + 1'b1;
            end else begin
                st_d.phase = st_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1: a short-kind slot never lets the phase run past its 8-sample period
    p_phase_short_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide_i) |-> (st_q.phase <= PH_END_A));

    // R2: a long-kind slot never counts more than five periods
    p_rep_long_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wide_i |-> (st_q.rep <= RP_END_B));

    // R5: the filler slot is a single period
    p_fill_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        short_i |-> (st_q.rep == '0));

endmodule

// File: rtl/fsktag_seq.sv
module fsktag_seq
    import fsktag_pkg::*;
#(
    parameter int                ID_W     = 44,
    parameter int                GROUP    = 4,
    parameter int                MARK_N   = 8,
    parameter logic [MARK_N-1:0] MARK_PAT = 8'b10111000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic            load_i,
    input  logic            smp_i,
    input  logic [ID_W-1:0] id_i,
    input  logic            last_i,
    output logic            run_o,
    output logic            adv_o,
    output logic            clr_o,
    output logic            wide_o,
    output logic            short_o,
    output logic            mark0_o
);

    localparam int BI_W = $clog2(ID_W);
    localparam int MI_W = $clog2(MARK_N);
    localparam logic [BI_W-1:0] BI_TOP = BI_W'(ID_W - 1);
    localparam logic [MI_W-1:0] MI_END = MI_W'(MARK_N - 1);

    typedef struct packed {
        logic            run;
        slot_e           slot;
        logic [MI_W-1:0] midx;
        logic [BI_W-1:0] bidx;
        logic [ID_W-1:0] id;
    } seq_t;

    seq_t            st_q, st_d;
    logic            step;
    logic            wrap;
    logic            cur_bit;
    logic [BI_W-1:0] bidx_dn;

    function automatic logic group_head(input logic [BI_W-1:0] bi);
        return (int'(bi) % GROUP) == (GROUP - 1);
    endfunction

    always_comb begin
        run_o   = st_q.run & en_i;
        adv_o   = run_o & smp_i & ~load_i;
        clr_o   = ~run_o | load_i;
        step    = adv_o & last_i;
        cur_bit = st_q.id[st_q.bidx];
        bidx_dn = st_q.bidx - 1'b1;
        wrap    = step && (st_q.slot == SLOT_HALF1) && (st_q.bidx == '0);

        case (st_q.slot)
            SLOT_MARK:  wide_o = MARK_PAT[st_q.midx];
            SLOT_FILL:  wide_o = 1'b0;
            SLOT_HALF0: wide_o = cur_bit;
            default:    wide_o = ~cur_bit;
        endcase
        short_o = (st_q.slot == SLOT_FILL);
        mark0_o = (st_q.slot == SLOT_MARK) && (st_q.midx == '0);

        st_d = st_q;
        if (!en_i) begin
            st_d.run  = 1'b0;
            st_d.slot = SLOT_MARK;
            st_d.midx = '0;
        end else if (load_i) begin
            st_d.run  = 1'b1;
            st_d.slot = SLOT_MARK;
            st_d.midx = '0;
            st_d.id   = id_i;
        end else if (step) begin
            case (st_q.slot)
                SLOT_MARK: begin
                    if (st_q.midx == MI_END) begin
                        st_d.bidx = BI_TOP;
                        st_d.slot = group_head(BI_TOP) ? SLOT_FILL : SLOT_HALF0;
                    end else begin
                        st_d.midx = st_q.midx + 1'b1;
                    end
                end
                SLOT_FILL:  st_d.slot = SLOT_HALF0;
                SLOT_HALF0: st_d.slot = SLOT_HALF1;
                default: begin
                    if (st_q.bidx == '0) begin
                        st_d.slot = SLOT_MARK;
                        st_d.midx = '0;
                        st_d.id   = id_i;
                    end else begin
                        st_d.bidx = bidx_dn;
                        st_d.slot = group_head(bidx_dn) ? SLOT_FILL : SLOT_HALF0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.slot <= SLOT_MARK;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: with no strobe and no start request the frame position holds
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !load_i && !smp_i) |=>
            ($stable(st_q.slot) && $stable(st_q.midx) && $stable(st_q.bidx)));

    // R6: finishing bit 0 lands on the first marker half
    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ((st_q.slot == SLOT_MARK) && (st_q.midx == '0)));

    // R9: the held identifier only changes on a start request or a frame wrap
    p_idkeep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !wrap) |=> $stable(st_q.id));

endmodule

// File: rtl/fsk_tagwave.sv
module fsk_tagwave
    import fsktag_pkg::*;
#(
    parameter int                ID_W     = 44,
    parameter int                GROUP    = 4,
    parameter int                DIV_A    = 8,
    parameter int                HIGH_A   = 2,
    parameter int                REP_A    = 6,
    parameter int                DIV_B    = 10,
    parameter int                HIGH_B   = 3,
    parameter int                REP_B    = 5,
    parameter int                MARK_N   = 8,
    parameter logic [MARK_N-1:0] MARK_PAT = 8'b10111000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic            load_i,
    input  logic            smp_i,
    input  logic [ID_W-1:0] id_i,
    output logic            mod_o,
    output logic            sof_o
);

    logic run_w, adv_w, clr_w, wide_w, short_w, mark0_w;
    logic cbit_w, first_w, last_w;

    fsktag_seq #(
        .ID_W    (ID_W),
        .GROUP   (GROUP),
        .MARK_N  (MARK_N),
        .MARK_PAT(MARK_PAT)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en_i),
        .load_i (load_i),
        .smp_i  (smp_i),
        .id_i   (id_i),
        .last_i (last_w),
        .run_o  (run_w),
        .adv_o  (adv_w),
        .clr_o  (clr_w),
        .wide_o (wide_w),
        .short_o(short_w),
        .mark0_o(mark0_w)
    );

    fsktag_cell #(
        .DIV_A (DIV_A),
        .HIGH_A(HIGH_A),
        .REP_A (REP_A),
        .DIV_B (DIV_B),
        .HIGH_B(HIGH_B),
        .REP_B (REP_B)
    ) u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr_w),
        .adv_i  (adv_w),
        .wide_i (wide_w),
        .short_i(short_w),
        .bit_o  (cbit_w),
        .first_o(first_w),
        .last_o (last_w)
    );

    always_comb begin
        mod_o = run_w & cbit_w;
        sof_o = adv_w & mark0_w & first_w;
    end

    // R8: the frame flag only appears in a strobe cycle while enabled
    p_sof_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sof_o |-> (smp_i && en_i));

    // R4: the first marker sample is always a high sample
    p_sof_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sof_o |-> mod_o);

    // R10: once enable has been low, the next cycle carries no modulation
    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i) |=> !mod_o);

endmodule

// File: tb/sim_fsk_tagwave.sv
module sim_fsk_tagwave;

    localparam int ID_W    = 44;
    localparam int FRAME_N = 4792;
    localparam int NV      = 24;
    localparam logic [ID_W-1:0] ID_A = 44'h8F0_1234_5679;
    localparam logic [ID_W-1:0] ID_B = 44'h400_0000_0000;
    localparam logic [7:0] MARK_KINDS = 8'b10111000;

    // {identifier, sample index, expected bit}
    localparam logic [57:0] VEC [NV] = '{
        {ID_A, 13'd0,    1'b1},   // R4 marker start
        {ID_A, 13'd1,    1'b1},   // R4
        {ID_A, 13'd2,    1'b0},   // R4
        {ID_A, 13'd144,  1'b1},   // R4 first long marker half
        {ID_A, 13'd147,  1'b0},   // R4
        {ID_A, 13'd294,  1'b1},   // R4 short half after three long
        {ID_A, 13'd296,  1'b0},   // R4
        {ID_A, 13'd344,  1'b1},   // R4 last marker half is long
        {ID_A, 13'd345,  1'b0},   // R4
        {ID_A, 13'd392,  1'b1},   // R5 filler before bit 43
        {ID_A, 13'd393,  1'b1},   // R5
        {ID_A, 13'd394,  1'b0},   // R5
        {ID_A, 13'd400,  1'b1},   // R3 bit 43 = 1: long half first
        {ID_A, 13'd403,  1'b0},   // R3
        {ID_A, 13'd452,  1'b0},   // R3 second half short
        {ID_A, 13'd500,  1'b0},   // R3 bit 42 = 0: short half
        {ID_A, 13'd4742, 1'b0},   // R3 bit 0 = 1
        {ID_A, 13'd4792, 1'b1},   // R6 wrap to marker
        {ID_B, 13'd401,  1'b1},   // R3 bit 43 = 0: short half first
        {ID_B, 13'd402,  1'b0},   // R3
        {ID_B, 13'd448,  1'b1},   // R3 long second half
        {ID_B, 13'd451,  1'b0},   // R3
        {ID_B, 13'd500,  1'b1},   // R3 bit 42 = 1: long half
        {ID_B, 13'd4742, 1'b1}    // R3 bit 0 = 0
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            en_i = 1'b0;
    logic            load_i = 1'b0;
    logic            smp_i = 1'b0;
    logic [ID_W-1:0] id_i = '0;
    logic            mod_o, sof_o;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    fsk_tagwave u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (en_i),
        .load_i(load_i),
        .smp_i (smp_i),
        .id_i  (id_i),
        .mod_o (mod_o),
        .sof_o (sof_o)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: got %0d cycles expected below 190000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int pat(input logic w, input int r);
        if (w) return ((r % 10) < 3) ? 1 : 0;
        return ((r % 8) < 2) ? 1 : 0;
    endfunction

    // returns expected bit + 2 * kind; kind 1 short data half, 2 long data half,
    // 3 filler, 4 marker
    function automatic int model(input logic [ID_W-1:0] id, input int p);
        int off = 0;
        int len;
        logic w;
        for (int h = 0; h < 8; h++) begin
            w = MARK_KINDS[h];
            len = w ? 50 : 48;
            if (p < off + len) return 8 + pat(w, p - off);
            off += len;
        end
        for (int b = ID_W - 1; b >= 0; b--) begin
            if (b % 4 == 3) begin
                if (p < off + 8) return 6 + pat(1'b0, p - off);
                off += 8;
            end
            for (int hh = 0; hh < 2; hh++) begin
                w = (hh == 0) ? id[b] : ~id[b];
                len = w ? 50 : 48;
                if (p < off + len) return (w ? 4 : 2) + pat(w, p - off);
                off += len;
            end
        end
        return -1;
    endfunction

    task automatic do_load(input logic [ID_W-1:0] id);
        @(negedge clk);
        id_i   = id;
        load_i = 1'b1;
        smp_i  = 1'b0;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic take(output logic m, output logic s);
        smp_i = 1'b1;
        #1;
        m = mod_o;
        s = sof_o;
        @(negedge clk);
        smp_i = 1'b0;
    endtask

    initial begin
        logic m, s;
        int e_short, e_long, e_fill, e_mark, sof_bad, errs, errs2, bad;
        int r;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!mod_o && !sof_o, "R12 reset outputs", {mod_o, sof_o}, 0);
        en_i = 1'b1;
        smp_i = 1'b1;
        bad = 0;
        for (int k = 0; k < 30; k++) begin
            #1;
            if (mod_o || sof_o) bad++;
            @(negedge clk);
        end
        smp_i = 1'b0;
        chk(bad == 0, "R12 idle without start", bad, 0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            logic [ID_W-1:0] vid;
            int idx;
            logic ev;
            string tag;
            vid = VEC[v][57:14];
            idx = int'(VEC[v][13:1]);
            ev  = VEC[v][0];
            tag = (idx < 392) ? "R4" : (idx < 400) ? "R5" : (idx >= FRAME_N) ? "R6" : "R3";
            do_load(vid);
            for (int k = 0; k < idx; k++) take(m, s);
            take(m, s);
            chk(m == ev, tag, m, ev);
        end

        // full frame against model
        do_load(ID_A);
        e_short = 0; e_long = 0; e_fill = 0; e_mark = 0; sof_bad = 0;
        for (int p = 0; p < FRAME_N; p++) begin
            take(m, s);
            r = model(ID_A, p);
            if (m != r[0]) begin
                case (r >> 1)
                    1: e_short++;
                    2: e_long++;
                    3: e_fill++;
                    default: e_mark++;
                endcase
            end
            if (s != (p == 0)) sof_bad++;
        end
        chk(e_short == 0, "R1 short halves", e_short, 0);
        chk(e_long == 0, "R2 long halves", e_long, 0);
        chk(e_fill == 0, "R5 filler periods", e_fill, 0);
        chk(e_mark == 0, "R4 start marker", e_mark, 0);
        chk(sof_bad == 0, "R8 frame flag", sof_bad, 0);
        take(m, s);
        chk(m && s, "R6 wrap without gap", {m, s}, 3);

        // identifier change in mid-frame
        do_load(ID_A);
        errs = 0; errs2 = 0;
        for (int p = 0; p < FRAME_N; p++) begin
            if (p == 1000) id_i = ID_B;
            take(m, s);
            r = model(ID_A, p);
            if (m != r[0]) errs++;
        end
        for (int p = 0; p < FRAME_N; p++) begin
            take(m, s);
            r = model(ID_B, p);
            if (m != r[0]) errs2++;
        end
        chk(errs == 0, "R9 frame keeps old identifier", errs, 0);
        chk(errs2 == 0, "R9 next frame uses new identifier", errs2, 0);

        // sparse strobes
        do_load(ID_B);
        errs = 0;
        for (int p = 0; p < 600; p++) begin
            take(m, s);
            r = model(ID_B, p);
            if (m != r[0]) errs++;
            repeat (2) @(negedge clk);
        end
        chk(errs == 0, "R7 gaps between strobes", errs, 0);

        // restart in mid-frame
        do_load(ID_A);
        for (int p = 0; p < 700; p++) take(m, s);
        do_load(ID_B);
        take(m, s);
        chk(m && s, "R11 restart at marker", {m, s}, 3);
        errs = 0;
        for (int p = 1; p < 520; p++) begin
            take(m, s);
            r = model(ID_B, p);
            if (m != r[0]) errs++;
        end
        chk(errs == 0, "R11 restarted stream", errs, 0);

        // enable dropped in mid-frame
        do_load(ID_A);
        for (int p = 0; p < 50; p++) take(m, s);
        en_i = 1'b0;
        smp_i = 1'b1;
        bad = 0;
        for (int k = 0; k < 20; k++) begin
            #1;
            if (mod_o || sof_o) bad++;
            if (k == 5) load_i = 1'b1;
            if (k == 6) load_i = 1'b0;
            @(negedge clk);
        end
        load_i = 1'b0;
        chk(bad == 0, "R10 quiet while disabled", bad, 0);
        en_i = 1'b1;
        bad = 0;
        for (int k = 0; k < 100; k++) begin
            #1;
            if (mod_o || sof_o) bad++;
            @(negedge clk);
        end
        smp_i = 1'b0;
        chk(bad == 0, "R10 no resume without start", bad, 0);
        do_load(ID_A);
        errs = 0;
        for (int p = 0; p < 100; p++) begin
            take(m, s);
            r = model(ID_A, p);
            if (m != r[0]) errs++;
        end
        chk(errs == 0, "R10 start after re-enable", errs, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule